// File: doc/BRIEF.md
# SMBus Register Port with Alert Response and Bus-Release Timeout

This block is a serial-bus slave that reaches an external 8-bit register file through an internal pointer. The first byte the host writes after the slave address always loads the pointer. Any further byte in the same write goes to the register the pointer names. The pointer never steps on its own. A read returns the register at the stored pointer, so a host can poll one register again and again without a fresh pointer write. Send byte, write byte, receive byte and read byte all map onto this scheme, and a repeated start can stand in for a stop between two of them.

SCL and SDA are sampled on a fast system clock through two-flop synchronizers. The only bus output is an open-drain pull-down enable for SDA. While an external alert request is high, the block also answers the alert response address and returns its own address byte. If a transaction stalls with no SCL edge for a configured time, the block drops back to idle and lets go of SDA. One bit of the configuration register turns this timeout off. Another bit of that register sets a lock that holds until reset. While locked, writes to the protected register range are acknowledged but never reach the register file.

Top module: `smb_regport`

## Requirements
- R1: The block acknowledges, by pulling SDA low in the ninth clock, an address byte whose upper seven bits are 0x2E. It does not pull SDA for any other address (apart from R7), and it then ignores the bus until the next start.
- R2: In a write, the first byte after the address loads the pointer. Each later byte in the same write pulses the write port once, with the pointer as address. The pointer does not advance between bytes.
- R3: A read sends the register at the current pointer, MSB first. Repeated reads without a pointer write return the same register.
- R4: A repeated start ends the current operation and begins a new address phase without a stop.
- R5: After each transmitted byte, a master ACK makes the block send the same pointer's register again. A master NACK makes it release SDA and go idle.
- R6: A stop (SDA rising while SCL is high) returns the block to idle with SDA released, from any state.
- R7: While alert_req is high, a read addressed to 0x0C is acknowledged and returns 0x5C. While alert_req is low, that address is not acknowledged.
- R8: If a transaction sees no SCL edge for TIMEOUT_MS milliseconds of clk, the block releases SDA and goes idle. Writing 1 to bit 6 of register 0x40 disables this timeout, and writing 0 to that bit enables it again.
- R9: Writing register 0x40 with bit 1 set locks registers 0x40 to 0x7F until reset. The write that sets the lock is itself performed. Later writes to the range are acknowledged but produce no write-port pulse.
- R10: SDA pull-down is only asserted while the synchronized SCL is low. The reset state has SDA released, the pointer at 0 and the write port idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| alert_req | input | 1 | High while this device requests attention |
| sda_pull | output | 1 | 1 = drive SDA low |
| reg_rd_addr | output | 8 | Register file read address (the pointer) |
| reg_rd_data | input | 8 | Register file read data |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_addr | output | 8 | Write address |
| reg_wr_data | output | 8 | Write data |

## Verification
The lock check and the commit of the locking write meet on the same clock edge. The byte that sets the lock has to be performed, while the next byte to the same pointer has to be dropped. The bench provokes this with one write transaction that carries two data bytes to register 0x40, the first setting the lock bit. It judges the result from the register file the write port fills and from the ACK the host sees on the second byte. The timeout counter and a slave-held data bit also overlap: the bench stalls SCL low while the block drives a zero, once with the timeout enabled and once with it disabled, and checks that the pull-down is dropped or kept.

// File: rtl/smb_regport_pkg.sv
package smb_regport_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_RX,
    ST_ACK_RX,
    ST_TX,
    ST_TX_ACK
  } smb_state_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout
);
  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] pipe_q;
      always_ff @(posedge clk) begin
        if (rst) pipe_q <= '1;
        else     pipe_q <= {pipe_q[STAGES-2:0], din[g]};
      end
      assign dout[g] = pipe_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/smb_cond_det.sv
module smb_cond_det (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_d, sda_d;
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end
  assign scl_rise  = ~scl_d & scl_s;
  assign scl_fall  = scl_d & ~scl_s;
  assign start_det = scl_d & scl_s & sda_d & ~sda_s;
  assign stop_det  = scl_d & scl_s & ~sda_d & sda_s;
endmodule

// File: rtl/smb_idle_timer.sv
module smb_idle_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic activity,
  input  logic enable,
  output logic fire
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);
  logic [CW-1:0] cnt_q;
  always_ff @(posedge clk) begin
    if (rst || !active || activity) cnt_q <= '0;
    else if (cnt_q != LIM)          cnt_q <= cnt_q + 1'b1;
  end
  assign fire = enable && active && (cnt_q == LIM);
endmodule

// File: rtl/smb_regport.sv
module smb_regport
  import smb_regport_pkg::*;
#(
  parameter int          CLK_HZ     = 50_000_000,
  parameter int          TIMEOUT_MS = 35,
  parameter int          AW         = 8,
  parameter int          DW         = 8,
  parameter logic [6:0]  DEV_ADDR   = 7'h2E,
  parameter logic [6:0]  ARA_ADDR   = 7'h0C,
  parameter logic [AW-1:0] CFG_ADDR = 8'h40,
  parameter int          TODIS_BIT  = 6,
  parameter int          LOCK_BIT   = 1,
  parameter logic [AW-1:0] PROT_LO  = 8'h40,
  parameter logic [AW-1:0] PROT_HI  = 8'h7F
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          alert_req,
  output logic          sda_pull,
  output logic [AW-1:0] reg_rd_addr,
  input  logic [DW-1:0] reg_rd_data,
  output logic          reg_wr_en,
  output logic [AW-1:0] reg_wr_addr,
  output logic [DW-1:0] reg_wr_data
);
  localparam int TMO_CYC = (CLK_HZ / 1000) * TIMEOUT_MS;

  logic [1:0] lines_s;
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, tmo_fire;

  smb_line_sync #(.LINES(2), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .din({scl_i, sda_i}), .dout(lines_s));
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  smb_cond_det u_det (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  smb_state_e    state_q;
  logic [3:0]    nbits_q;
  logic [7:0]    shreg_q;
  logic          rw_q, ara_q, first_q, ack_seen_q;
  logic [AW-1:0] ptr_q;
  logic          lock_q, tmo_dis_q;
  logic          pull_q;
  logic          wr_en_q;
  logic [AW-1:0] wr_addr_q;
  logic [DW-1:0] wr_data_q;
  logic          in_idle;

  assign in_idle = (state_q == ST_IDLE);

  smb_idle_timer #(.LIMIT(TMO_CYC)) u_tmo (
    .clk(clk), .rst(rst), .active(!in_idle),
    .activity(scl_rise | scl_fall | start_det),
    .enable(!tmo_dis_q), .fire(tmo_fire));

  logic [7:0] tx_byte;
  logic       dev_hit, ara_hit, ptr_prot;
  assign tx_byte  = ara_q ? {DEV_ADDR, 1'b0} : reg_rd_data;
  assign dev_hit  = (shreg_q[7:1] == DEV_ADDR);
  assign ara_hit  = (shreg_q[7:1] == ARA_ADDR) && shreg_q[0] && alert_req;
  assign ptr_prot = (ptr_q >= PROT_LO) && (ptr_q <= PROT_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      nbits_q    <= '0;
      shreg_q    <= '0;
      rw_q       <= 1'b0;
      ara_q      <= 1'b0;
      first_q    <= 1'b0;
      ack_seen_q <= 1'b0;
      ptr_q      <= '0;
      lock_q     <= 1'b0;
      tmo_dis_q  <= 1'b0;
      pull_q     <= 1'b0;
      wr_en_q    <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (stop_det || tmo_fire) begin
        state_q <= ST_IDLE;
        pull_q  <= 1'b0;
      end else if (start_det) begin
        state_q <= ST_ADDR;
        nbits_q <= '0;
        pull_q  <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg_q <= {shreg_q[6:0], sda_s};
              nbits_q <= nbits_q + 1'b1;
            end else if (scl_fall && nbits_q == 4'd8) begin
              if (dev_hit || ara_hit) begin
                pull_q  <= 1'b1;
                rw_q    <= shreg_q[0];
                ara_q   <= ara_hit && !dev_hit;
                state_q <= ST_ACK_ADDR;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_ACK_ADDR: begin
            if (scl_fall) begin
              if (rw_q) begin
                pull_q  <= ~tx_byte[7];
                shreg_q <= {tx_byte[6:0], 1'b0};
                nbits_q <= 4'd1;
                state_q <= ST_TX;
              end else begin
                pull_q  <= 1'b0;
                nbits_q <= '0;
                first_q <= 1'b1;
                state_q <= ST_RX;
              end
            end
          end
          ST_RX: begin
            if (scl_rise) begin
              shreg_q <= {shreg_q[6:0], sda_s};
              nbits_q <= nbits_q + 1'b1;
            end else if (scl_fall && nbits_q == 4'd8) begin
              pull_q  <= 1'b1;
              state_q <= ST_ACK_RX;
              if (first_q) begin
                ptr_q   <= shreg_q;
                first_q <= 1'b0;
              end else if (!(lock_q && ptr_prot)) begin
                wr_en_q   <= 1'b1;
                wr_addr_q <= ptr_q;
                wr_data_q <= shreg_q;
                if (ptr_q == CFG_ADDR) begin
                  tmo_dis_q <= shreg_q[TODIS_BIT];
                  if (shreg_q[LOCK_BIT]) lock_q <= 1'b1;
                end
              end
            end
          end
          ST_ACK_RX: begin
            if (scl_fall) begin
              pull_q  <= 1'b0;
              nbits_q <= '0;
              state_q <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (nbits_q == 4'd8) begin
                pull_q  <= 1'b0;
                state_q <= ST_TX_ACK;
              end else begin
                pull_q  <= ~shreg_q[7];
                shreg_q <= {shreg_q[6:0], 1'b0};
                nbits_q <= nbits_q + 1'b1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              ack_seen_q <= ~sda_s;
            end else if (scl_fall) begin
              if (ack_seen_q) begin
                pull_q  <= ~tx_byte[7];
                shreg_q <= {tx_byte[6:0], 1'b0};
                nbits_q <= 4'd1;
                state_q <= ST_TX;
              end else begin
                pull_q  <= 1'b0;
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull    = pull_q;
  assign reg_rd_addr = ptr_q;
  assign reg_wr_en   = wr_en_q;
  assign reg_wr_addr = wr_addr_q;
  assign reg_wr_data = wr_data_q;
endmodule

// File: rtl/smb_regport_chk.sv
module smb_regport_chk (
  input logic clk,
  input logic rst,
  input logic scl_s,
  input logic sda_pull,
  input logic stop_det,
  input logic tmo_fire,
  input logic lock_q,
  input logic reg_wr_en,
  input logic in_idle
);
  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_pull)) |-> !scl_s);                            // R10
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_pull);                                  // R6
  AST_TMO_RELEASE: assert property (@(posedge clk) disable iff (rst)
    tmo_fire |=> (!sda_pull && in_idle));                     // R8
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);                                       // R9
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |=> !reg_wr_en);                                // R2
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    in_idle |-> !sda_pull);                                   // R1
endmodule

bind smb_regport smb_regport_chk u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .sda_pull(sda_pull),
  .stop_det(stop_det), .tmo_fire(tmo_fire), .lock_q(lock_q),
  .reg_wr_en(reg_wr_en), .in_idle(in_idle));

// File: tb/smb_regport_test.sv
`timescale 1ns/1ps
module smb_regport_test;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1, alert_req = 1'b0;
  logic sda_pull, reg_wr_en;
  logic [7:0] reg_rd_addr, reg_wr_addr, reg_wr_data, reg_rd_data;
  logic sda_line;
  logic [7:0] mem [256];
  int tests = 0, fails = 0, wr_cnt = 0;

  always #10 clk = ~clk;

  assign sda_line    = sda_m & ~sda_pull;
  assign reg_rd_data = mem[reg_rd_addr];

  smb_regport #(.CLK_HZ(20_000), .TIMEOUT_MS(35)) uut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .alert_req(alert_req), .sda_pull(sda_pull),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data));

  always @(posedge clk) if (reg_wr_en) begin
    mem[reg_wr_addr] <= reg_wr_data;
    wr_cnt <= wr_cnt + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    sda_m = 1'b0; tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = ~sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic master_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl_m = 1'b1; tick(Q);
      b[i] = sda_line; tick(Q);
      scl_m = 1'b0;
    end
    tick(Q);
    sda_m = ~master_ack; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(1);
    sda_m = 1'b1;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d, output logic ack_d);
    logic k;
    bus_start();
    send_byte(8'h5C, k);
    send_byte(a, k);
    send_byte(d, ack_d);
    bus_stop();
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    logic k;
    bus_start();
    send_byte(8'h5C, k);
    send_byte(a, k);
    bus_start();
    send_byte(8'h5D, k);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  task automatic t_reset();
    chk(sda_pull == 1'b0, "R10 reset sda", sda_pull, 0);
    chk(reg_rd_addr == 8'h00, "R10 reset ptr", reg_rd_addr, 0);
    chk(reg_wr_en == 1'b0, "R10 reset wr", reg_wr_en, 0);
  endtask

  task automatic t_addr();
    logic k; int w0;
    w0 = wr_cnt;
    bus_start(); send_byte(8'h5A, k); send_byte(8'h10, k);
    chk(k == 1'b0, "R1 foreign addr nack", k, 0);
    bus_stop();
    chk(wr_cnt == w0, "R1 no write", wr_cnt, w0);
    bus_start(); send_byte(8'h5C, k);
    chk(k == 1'b1, "R1 own addr ack", k, 1);
    bus_stop();
    chk(sda_pull == 1'b0, "R6 stop releases", sda_pull, 0);
  endtask

  task automatic t_write_read();
    logic k; logic [7:0] d; int w0;
    wr_reg(8'h10, 8'h35, k);
    chk(mem[8'h10] == 8'h35, "R2 write byte", mem[8'h10], 8'h35);
    w0 = wr_cnt;
    bus_start(); send_byte(8'h5C, k); send_byte(8'h30, k);
    send_byte(8'h11, k); send_byte(8'h22, k); bus_stop();
    chk(mem[8'h30] == 8'h22, "R2 no auto-increment", mem[8'h30], 8'h22);
    chk(mem[8'h31] == 8'h00, "R2 next reg untouched", mem[8'h31], 0);
    chk(wr_cnt == w0 + 2, "R2 one pulse per byte", wr_cnt, w0 + 2);
    rd_reg(8'h10, d);
    chk(d == 8'h35, "R4 read after repeated start", d, 8'h35);
    bus_start(); send_byte(8'h5D, k); recv_byte(1'b0, d); bus_stop();
    chk(d == 8'h35, "R3 receive byte at stored ptr", d, 8'h35);
    bus_start(); send_byte(8'h5C, k); send_byte(8'h30, k); bus_stop();
    bus_start(); send_byte(8'h5D, k); recv_byte(1'b1, d);
    chk(d == 8'h22, "R3 send byte then receive", d, 8'h22);
    recv_byte(1'b0, d);
    chk(d == 8'h22, "R5 ack repeats same reg", d, 8'h22);
    chk(sda_pull == 1'b0, "R5 nack releases", sda_pull, 0);
    bus_stop();
  endtask

  task automatic t_ara();
    logic k; logic [7:0] d;
    alert_req = 1'b0;
    bus_start(); send_byte(8'h19, k); bus_stop();
    chk(k == 1'b0, "R7 no alert no ack", k, 0);
    alert_req = 1'b1;
    bus_start(); send_byte(8'h19, k);
    chk(k == 1'b1, "R7 alert ack", k, 1);
    recv_byte(1'b0, d); bus_stop();
    chk(d == 8'h5C, "R7 returns own address", d, 8'h5C);
    alert_req = 1'b0;
  endtask

  task automatic t_timeout();
    logic k; logic [7:0] d;
    bus_start(); send_byte(8'h5C, k); send_byte(8'h10, k);
    bus_start(); send_byte(8'h5D, k);
    tick(Q);
    chk(sda_pull == 1'b1, "R8 slave holds bit", sda_pull, 1);
    tick(1000);
    chk(sda_pull == 1'b0, "R8 timeout release", sda_pull, 0);
    bus_stop();
    wr_reg(8'h40, 8'h40, k);
    bus_start(); send_byte(8'h5C, k); send_byte(8'h10, k);
    bus_start(); send_byte(8'h5D, k);
    tick(1000);
    chk(sda_pull == 1'b1, "R8 timeout disabled holds", sda_pull, 1);
    recv_byte(1'b0, d); bus_stop();
    chk(d == 8'h35, "R8 transfer resumes", d, 8'h35);
  endtask

  task automatic t_lock();
    logic k; logic [7:0] d; int w0;
    w0 = wr_cnt;
    bus_start(); send_byte(8'h5C, k); send_byte(8'h40, k);
    send_byte(8'h02, k); send_byte(8'hFF, k); bus_stop();
    chk(mem[8'h40] == 8'h02, "R9 locking write done", mem[8'h40], 8'h02);
    chk(k == 1'b1, "R9 locked byte acked", k, 1);
    chk(wr_cnt == w0 + 1, "R9 second byte dropped", wr_cnt, w0 + 1);
    wr_reg(8'h41, 8'h99, k);
    chk(mem[8'h41] == 8'h00 && k, "R9 protected ignored", mem[8'h41], 0);
    wr_reg(8'h20, 8'h77, k);
    chk(mem[8'h20] == 8'h77, "R9 unprotected still writes", mem[8'h20], 8'h77);
    rd_reg(8'h20, d);
    chk(d == 8'h77, "R3 read back", d, 8'h77);
    rst = 1'b1; tick(4); rst = 1'b0; tick(4);
    t_reset();
    wr_reg(8'h41, 8'h99, k);
    chk(mem[8'h41] == 8'h99, "R9 reset clears lock", mem[8'h41], 8'h99);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    tick(5); rst = 1'b0; tick(5);
    t_reset();
    t_addr();
    t_write_read();
    t_ara();
    t_timeout();
    t_lock();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule